// File: doc/BRIEF.md
# Hybrid Static/Dynamic Branch Predictor

This block gives a simple in-order fetch stage a taken/not-taken guess for each conditional branch. A direct-mapped history table holds one two-bit saturating counter per entry, together with a tag and a valid bit. When the table holds a valid entry whose tag matches the fetch PC, the guess is the counter's upper bit. When there is no such entry, a direction rule decides instead. A branch that jumps backward, or to itself, is guessed taken, because loop-closing branches usually repeat. A branch that jumps forward is guessed not taken, unless the instruction carries an explicit taken hint.

The prediction is a combinational function of the query inputs. Resolved outcomes arrive on a separate update port and are written on the clock edge. The first outcome seen for a PC allocates its entry in the weak state of that outcome. Later outcomes move the counter one step and saturate at the ends. A second output reports which path produced the guess, so the fetch logic and the bench can both see it.

Top module: `bpred_hybrid`

## Requirements
- R1: A counter is encoded 2'b00 strong not-taken, 2'b01 weak not-taken, 2'b10 weak taken and 2'b11 strong taken. When the query hits a valid entry with a matching tag, pred_taken equals bit 1 of that counter.
- R2: Reset (rst_n low) clears every valid bit. Every query made after reset, before any update, takes the static path.
- R3: On the static path with q_hint low and a positive q_ofs (forward branch), pred_taken is 0.
- R4: On the static path, a negative or zero q_ofs (backward or self branch) gives pred_taken 1.
- R5: On the static path, q_hint high forces pred_taken to 1. On the dynamic path, q_hint has no effect.
- R6: An update whose PC misses (invalid entry or tag mismatch) allocates the entry with counter 2'b10 if u_taken is 1 and 2'b01 otherwise.
- R7: An update that hits adds one to the counter for a taken outcome and subtracts one for a not-taken outcome. The counter stays at 2'b11 and at 2'b00 at the ends. As a result, two not-taken outcomes after a weak-taken state give a not-taken guess.
- R8: The entry index is PC bits [7:2] and the tag is PC bits [31:8]. Two PCs that share an index but differ in tag do not see each other's history, and an update of one replaces the entry of the other.
- R9: An update becomes visible on the cycle after its clock edge. A query in the same cycle as an update to the same entry sees the value from before the update.
- R10: used_static is 1 exactly when no valid entry with a matching tag exists for q_pc, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q_pc | input | 30 | Query PC, bits [31:2] |
| q_ofs | input | 16 | Signed branch offset of the queried branch |
| q_hint | input | 1 | Taken hint carried by the queried instruction |
| u_valid | input | 1 | Resolved-outcome update strobe |
| u_pc | input | 30 | Update PC, bits [31:2] |
| u_taken | input | 1 | Resolved outcome, 1 = taken |
| pred_taken | output | 1 | Predicted direction |
| used_static | output | 1 | 1 when the direction rule or hint decided |

## Verification
A corrupted counter shows up on the first query to that entry after the fault. It gives a wrong pred_taken if its upper bit flipped. If only the lower bit flipped, the error shows one update later, when the saturation point or the step is wrong. A stuck or wrongly set valid bit, or a bad tag, appears at once as a wrong used_static level. Aliased PCs and same-cycle query/update pairs can expose such faults within one cycle. The bench therefore compares both outputs against its own model on every cycle, through directed sequences and a pseudo-random mix over a small set of PCs that share indexes.

// File: rtl/bpred_pkg.sv
package bpred_pkg;
  typedef enum logic [1:0] {
    CTR_SNT = 2'b00,
    CTR_WNT = 2'b01,
    CTR_WT  = 2'b10,
    CTR_ST  = 2'b11
  } bp_ctr_e;
endpackage

// File: rtl/bp_static_rule.sv
module bp_static_rule #(
  parameter int OFS_W = 16
) (
  input  logic signed [OFS_W-1:0] ofs,
  input  logic                    hint,
  output logic                    take
);
  logic is_backward;

  // Zero offset is a self loop and counts as backward.
  always_comb begin
    is_backward = ofs[OFS_W-1] | (ofs == '0);
    take        = hint | is_backward;
  end
endmodule

// File: rtl/bp_ctr_next.sv
module bp_ctr_next
  import bpred_pkg::*;
(
  input  logic    hit,
  input  bp_ctr_e cur,
  input  logic    taken,
  output bp_ctr_e nxt
);
  logic [1:0] cur_raw;

  always_comb begin
    cur_raw = cur;
    if (!hit) begin
      nxt = taken ? CTR_WT : CTR_WNT;
    end else if (taken) begin
      nxt = (cur == CTR_ST) ? CTR_ST : bp_ctr_e'(cur_raw + 2'd1);
    end else begin
      nxt = (cur == CTR_SNT) ? CTR_SNT : bp_ctr_e'(cur_raw - 2'd1);
    end
  end
endmodule

// File: rtl/bp_hist_table.sv
module bp_hist_table
  import bpred_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int TAG_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [TAG_W-1:0] rd_tag,
  output logic             rd_hit,
  output bp_ctr_e          rd_ctr,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  output logic             wr_hit,
  output bp_ctr_e          wr_cur,
  input  logic             wr_en,
  input  bp_ctr_e          wr_ctr
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] vld_q, vld_d;
  logic [TAG_W-1:0] tag_q [DEPTH];
  bp_ctr_e          ctr_q [DEPTH];

  // Two combinational read ports: query side and update side.
  always_comb begin
    rd_hit = vld_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
    rd_ctr = ctr_q[rd_idx];
    wr_hit = vld_q[wr_idx] && (tag_q[wr_idx] == wr_tag);
    wr_cur = ctr_q[wr_idx];
  end

  always_comb begin
    vld_d = vld_q;
    if (wr_en) vld_d[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  // Payload storage needs no reset: it is qualified by vld_q.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx] <= wr_tag;
      ctr_q[wr_idx] <= wr_ctr;
    end
  end

  // R6
  alloc_weak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_hit) |-> (wr_ctr == CTR_WT || wr_ctr == CTR_WNT));

  // R7
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_hit && wr_ctr == wr_cur) |-> (wr_cur == CTR_ST || wr_cur == CTR_SNT));

  // R9
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (vld_q[$past(wr_idx)] && ctr_q[$past(wr_idx)] == $past(wr_ctr)
               && tag_q[$past(wr_idx)] == $past(wr_tag)));
endmodule

// File: rtl/bpred_hybrid.sv
module bpred_hybrid
  import bpred_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int ALIGN_W = 2,
  parameter int IDX_W   = 6,
  parameter int OFS_W   = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [PC_W-1:ALIGN_W]   q_pc,
  input  logic signed [OFS_W-1:0] q_ofs,
  input  logic                    q_hint,
  input  logic                    u_valid,
  input  logic [PC_W-1:ALIGN_W]   u_pc,
  input  logic                    u_taken,
  output logic                    pred_taken,
  output logic                    used_static
);
  localparam int TAG_LSB = ALIGN_W + IDX_W;
  localparam int TAG_W   = PC_W - TAG_LSB;

  logic [IDX_W-1:0] q_idx, u_idx;
  logic [TAG_W-1:0] q_tag, u_tag;
  logic             q_hit, u_hit, static_take;
  bp_ctr_e          q_ctr, u_cur, u_nxt;

  assign q_idx = q_pc[TAG_LSB-1:ALIGN_W];
  assign q_tag = q_pc[PC_W-1:TAG_LSB];
  assign u_idx = u_pc[TAG_LSB-1:ALIGN_W];
  assign u_tag = u_pc[PC_W-1:TAG_LSB];

  bp_hist_table #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tab (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_idx (q_idx),
    .rd_tag (q_tag),
    .rd_hit (q_hit),
    .rd_ctr (q_ctr),
    .wr_idx (u_idx),
    .wr_tag (u_tag),
    .wr_hit (u_hit),
    .wr_cur (u_cur),
    .wr_en  (u_valid),
    .wr_ctr (u_nxt)
  );

  bp_ctr_next u_step (
    .hit   (u_hit),
    .cur   (u_cur),
    .taken (u_taken),
    .nxt   (u_nxt)
  );

  bp_static_rule #(.OFS_W(OFS_W)) u_rule (
    .ofs  (q_ofs),
    .hint (q_hint),
    .take (static_take)
  );

  always_comb begin
    used_static = !q_hit;
    pred_taken  = q_hit ? q_ctr[1] : static_take;
  end

  // R5
  hint_forces_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (used_static && q_hint) |-> pred_taken);

  // R2
  reset_static_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rst_n) || $past(!rst_n)) |-> used_static);
endmodule

// File: tb/test_bpred_hybrid.sv
`timescale 1ns/1ps
module test_bpred_hybrid;
  logic clk = 1'b0;
  logic rst_n;
  logic [31:0] qpc, upc;
  logic signed [15:0] q_ofs;
  logic q_hint, u_valid, u_taken;
  logic pred_taken, used_static;

  always #2.5 clk = ~clk;

  bpred_hybrid i_bpred_hybrid (
    .clk(clk), .rst_n(rst_n),
    .q_pc(qpc[31:2]), .q_ofs(q_ofs), .q_hint(q_hint),
    .u_valid(u_valid), .u_pc(upc[31:2]), .u_taken(u_taken),
    .pred_taken(pred_taken), .used_static(used_static)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // Behavioural reference: per-slot valid, full tag and integer counter.
  bit          m_vld [64];
  logic [23:0] m_tag [64];
  int          m_ctr [64];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; u_valid = 0; q_hint = 0; q_ofs = 16'sd4; qpc = 0; upc = 0; u_taken = 0;
    foreach (m_vld[i]) m_vld[i] = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // One cycle: drive, compare against model, then advance model on the edge.
  task automatic cyc(input logic [31:0] p, input logic signed [15:0] o, input logic h,
                     input logic uv, input logic [31:0] up, input logic ut, input string tag);
    int qi, ui;
    bit hit, uhit, exp_p;
    string rq;
    @(negedge clk);
    qpc = p; q_ofs = o; q_hint = h; u_valid = uv; upc = up; u_taken = ut;
    #1;
    qi  = p[7:2];
    hit = m_vld[qi] && (m_tag[qi] == p[31:8]);
    exp_p = hit ? (m_ctr[qi] >= 2) : (h || o <= 0);
    if (tag != "") rq = tag;
    else if (hit) rq = "R7";
    else if (h) rq = "R5";
    else rq = (o > 0) ? "R3" : "R4";
    check(used_static == !hit, "R10", used_static, !hit);
    check(pred_taken == exp_p, rq, pred_taken, exp_p);
    @(posedge clk);
    if (uv) begin
      ui   = up[7:2];
      uhit = m_vld[ui] && (m_tag[ui] == up[31:8]);
      if (uhit) begin
        if (ut) m_ctr[ui] = (m_ctr[ui] == 3) ? 3 : m_ctr[ui] + 1;
        else    m_ctr[ui] = (m_ctr[ui] == 0) ? 0 : m_ctr[ui] - 1;
      end else begin
        m_vld[ui] = 1; m_tag[ui] = up[31:8]; m_ctr[ui] = ut ? 2 : 1;
      end
    end
  endtask

  task automatic upd(input logic [31:0] up, input logic ut);
    cyc(32'h0000_0F00, 16'sd4, 0, 1, up, ut, "");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    do_reset();
    // R2: nothing valid after reset
    cyc(32'h100, 16'sd8,  0, 0, 0, 0, "R2");
    cyc(32'h200, -16'sd8, 0, 0, 0, 0, "R2");
    // R3 / R4 / R5 static rule
    cyc(32'h100, 16'sd8,  0, 0, 0, 0, "R3");
    cyc(32'h100, -16'sd8, 0, 0, 0, 0, "R4");
    cyc(32'h100, 16'sd0,  0, 0, 0, 0, "R4");
    cyc(32'h100, 16'sd8,  1, 0, 0, 0, "R5");
    // R6: allocate weak states
    upd(32'h200, 1);
    cyc(32'h200, 16'sd8,  0, 0, 0, 0, "R6");
    upd(32'h204, 0);
    cyc(32'h204, -16'sd16, 0, 0, 0, 0, "R6");
    cyc(32'h204, 16'sd8,  1, 0, 0, 0, "R5");   // hint ignored on dynamic path
    // R7: saturating steps, guard branch settles to not-taken
    repeat (3) upd(32'h200, 1);
    upd(32'h200, 0);
    cyc(32'h200, 16'sd8, 0, 0, 0, 0, "R7");
    upd(32'h200, 0);
    cyc(32'h200, 16'sd8, 0, 0, 0, 0, "R7");
    repeat (3) upd(32'h204, 0);
    upd(32'h204, 1);
    cyc(32'h204, -16'sd4, 0, 0, 0, 0, "R7");
    upd(32'h204, 1);
    cyc(32'h204, -16'sd4, 0, 0, 0, 0, "R1");
    // R9: same-cycle query/update sees old state
    cyc(32'h300, 16'sd4, 0, 1, 32'h300, 1, "R9");
    cyc(32'h300, 16'sd4, 0, 0, 0, 0, "R9");
    // R8: alias on index 0x300>>2 with a different tag
    cyc(32'h1_0300, 16'sd4, 0, 0, 0, 0, "R8");
    upd(32'h1_0300, 0);
    cyc(32'h300, -16'sd4, 0, 0, 0, 0, "R8");
    cyc(32'h1_0300, -16'sd4, 0, 0, 0, 0, "R8");
    // Pseudo-random mix over a few aliasing PCs
    lfsr = 16'hACE1;
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a, b;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a = {22'd0, lfsr[1:0], 6'd0, lfsr[3:2]} << 2;
      b = {22'd0, lfsr[5:4], 6'd0, lfsr[7:6]} << 2;
      cyc(a, lfsr[8] ? -16'sd12 : 16'sd12, lfsr[9], lfsr[10], b, lfsr[11], "");
    end
    // R2: reset in mid run clears learned history
    do_reset();
    cyc(32'h200, 16'sd8, 0, 0, 0, 0, "R2");
    cyc(32'h204, 16'sd8, 0, 0, 0, 0, "R2");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule